// File: doc/BRIEF.md
# Parallel Display Write-Cycle Engine

This block produces the write cycles of an 8080-style parallel display interface. It drives a data bus of `BUS_W` bits, a write strobe, a data/command select line and an active-low chip select. Each transaction runs up to three phases in fixed order: a command phase, an optional run of dummy beats, and a data phase. The command word is presented together with the start request. Data words arrive one per beat on a valid/ready stream whose last flag closes the data phase.

The strobe is made by integer division of the block clock. Every beat lasts twice the prescale value in clocks. During the first half of a beat the strobe sits at the level opposite the sampling edge, and the sampling edge falls in the middle of the beat. Configuration picks the strobe's resting level, the sampling edge, a select-line level for each of the four bus states, and optional byte swapping and bit reversal of data-phase words. When a transaction ends, the bus returns to rest and a one-clock completion pulse follows.

Top module: `disp8080_wr`

## Requirements
- R1: A transaction runs command beats, then `dummy_beats` dummy beats, then data beats, in that order. The command beat count is `cmd_width` divided by `BUS_W`, rounded up, so zero width means no command phase. The data phase runs only when `has_data` is 1, and it ends with the word that carries `s_last`.
- R2: The command value is masked to its low `cmd_width` bits and sent most significant bus word first. When the width is not a multiple of the bus width, the first word is zero-filled at its top (width 24 on a 16-bit bus sends 0x00AB then 0xCDEF for 0xABCDEF).
- R3: `lcd_dc` equals `cfg_dc_cmd`, `cfg_dc_dummy` or `cfg_dc_data` during the matching phase, and `cfg_dc_idle` whenever no transaction is active.
- R4: When no transaction is active, `lcd_wr` rests at `cfg_wr_idle_hi`. During a beat, `lcd_wr` is at level `cfg_sample_fall` for `cfg_prescale` clocks and then at the opposite level for `cfg_prescale` clocks. Back-to-back beats therefore put their sampling edges exactly 2×`cfg_prescale` clocks apart.
- R5: `lcd_data` changes only at the start of a beat. The value is stable across every sampling edge of `lcd_wr`.
- R6: In the data phase, `s_ready` is high only when a new beat can start. While no word is offered, `lcd_wr` stays at its non-sampling level and no sampling edge occurs.
- R7: For data-phase words, byte swap (`cfg_byte_swap`) first exchanges the two bytes of every 16-bit lane. Bit reversal (`cfg_bit_rev`) then maps bus bit i to bit `BUS_W-1-i`. Neither option touches command or dummy words.
- R8: Dummy beats drive an all-zero bus word.
- R9: After the last beat, `done` is high for exactly one clock. During that clock `lcd_cs_n` is 1, `lcd_dc` is at the idle level and `lcd_wr` is at its resting level. A start with no command, one dummy beat and no data also produces `done`.
- R10: A start with `cfg_prescale` equal to 0, `cfg_prescale` above `PRE_MAX`, or `cmd_width` above `CMD_W` is refused. `start_rej` is high in that cycle, and the bus stays at rest with no `done`.
- R11: After reset, `busy`, `done` and `s_ready` are 0, `lcd_cs_n` is 1, and `lcd_wr` and `lcd_dc` show their resting levels.
- R12: A start request while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prescale | input | PRE_W | Half-beat length in clocks, valid range 1..PRE_MAX |
| cfg_wr_idle_hi | input | 1 | Resting level of the write strobe |
| cfg_sample_fall | input | 1 | 1: display samples on the falling strobe edge, 0: on the rising edge |
| cfg_dc_idle | input | 1 | Select-line level when no transaction is active |
| cfg_dc_cmd | input | 1 | Select-line level in the command phase |
| cfg_dc_dummy | input | 1 | Select-line level in the dummy phase |
| cfg_dc_data | input | 1 | Select-line level in the data phase |
| cfg_bit_rev | input | 1 | Reverse bit order of data-phase words |
| cfg_byte_swap | input | 1 | Swap bytes within each 16-bit lane of data-phase words |
| start | input | 1 | Transaction request |
| cmd_value | input | CMD_W | Command value, right-aligned |
| cmd_width | input | CWW | Command width in bits, 0..CMD_W |
| dummy_beats | input | DUM_W | Number of dummy beats |
| has_data | input | 1 | Transaction includes a data phase |
| s_data | input | BUS_W | Stream data word |
| s_valid | input | 1 | Stream word valid |
| s_last | input | 1 | Stream word is the last of the data phase |
| s_ready | output | 1 | Engine accepts the stream word this cycle |
| lcd_data | output | BUS_W | Parallel display data bus |
| lcd_wr | output | 1 | Write strobe |
| lcd_dc | output | 1 | Data/command select |
| lcd_cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| start_rej | output | 1 | Start refused because of a bad setting |

## Verification
The bench builds the engine with a 16-bit bus, a 32-bit command limit, a prescale limit of 8 and a 4-bit dummy counter. At 16 bits, byte swapping has a lane to act on, and both a 32-bit and a 24-bit command split into two bus words, which exposes the zero-fill of a partial top word. The 4-bit prescale field can hold 9, so the over-limit refusal can be driven alongside the zero case, and the largest legal prescale sets the longest beat spacing checked.

// File: rtl/disp8080_wr.sv
module disp8080_wr #(
  parameter int BUS_W   = 16,
  parameter int CMD_W   = 32,
  parameter int PRE_MAX = 8,
  parameter int DUM_W   = 4,
  localparam int PRE_W  = $clog2(PRE_MAX + 1),
  localparam int CWW    = $clog2(CMD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic             cfg_wr_idle_hi,
  input  logic             cfg_sample_fall,
  input  logic             cfg_dc_idle,
  input  logic             cfg_dc_cmd,
  input  logic             cfg_dc_dummy,
  input  logic             cfg_dc_data,
  input  logic             cfg_bit_rev,
  input  logic             cfg_byte_swap,
  input  logic             start,
  input  logic [CMD_W-1:0] cmd_value,
  input  logic [CWW-1:0]   cmd_width,
  input  logic [DUM_W-1:0] dummy_beats,
  input  logic             has_data,
  input  logic [BUS_W-1:0] s_data,
  input  logic             s_valid,
  input  logic             s_last,
  output logic             s_ready,
  output logic [BUS_W-1:0] lcd_data,
  output logic             lcd_wr,
  output logic             lcd_dc,
  output logic             lcd_cs_n,
  output logic             busy,
  output logic             done,
  output logic             start_rej
);

  localparam int CNT_W = PRE_W + 1;
  localparam int NCMD  = CMD_W / BUS_W;
  localparam int NCW   = $clog2(NCMD + 1);
  localparam int LW    = (DUM_W > NCW) ? DUM_W : NCW;

  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_DUM, ST_DAT, ST_FIN} st_t;

  st_t              st, t_st, after_st, first_st;
  logic             beat_on, last_q, dat_q;
  logic [CNT_W-1:0] cnt;
  logic [LW-1:0]    left, t_left, n_cmd, first_left;
  logic [DUM_W-1:0] dum_q;
  logic [CMD_W-1:0] cmd_sh, cmd_aligned;
  logic [BUS_W-1:0] bus_q, sw_d, rv_d, fmt_d, word;
  logic [CWW:0]     ncmd_sum;

  wire start_ok = (cfg_prescale != '0) && (cfg_prescale <= PRE_W'(PRE_MAX))
                  && (cmd_width <= CWW'(CMD_W));
  wire in_phase = (st == ST_CMD) || (st == ST_DUM) || (st == ST_DAT);
  wire [CNT_W-1:0] beat_last = {cfg_prescale, 1'b0} - CNT_W'(1);
  wire at_bound = in_phase && (!beat_on || (cnt == beat_last));
  wire ph_over  = beat_on && ((st == ST_DAT) ? last_q : (left == LW'(1)));
  wire go = at_bound && ((t_st == ST_CMD) || (t_st == ST_DUM) || ((t_st == ST_DAT) && s_valid));

  assign ncmd_sum = {1'b0, cmd_width} + (CWW+1)'(BUS_W - 1);
  assign n_cmd    = LW'(ncmd_sum / (CWW+1)'(BUS_W));

  always_comb begin
    cmd_aligned = (cmd_value & ~({CMD_W{1'b1}} << cmd_width))
                  << (CMD_W - int'(n_cmd) * BUS_W);
    if (n_cmd != '0)             first_st = ST_CMD;
    else if (dummy_beats != '0)  first_st = ST_DUM;
    else if (has_data)           first_st = ST_DAT;
    else                         first_st = ST_FIN;
    first_left = (n_cmd != '0) ? n_cmd : LW'(dummy_beats);
  end

  always_comb begin
    case (st)
      ST_CMD:  after_st = (dum_q != '0) ? ST_DUM : (dat_q ? ST_DAT : ST_FIN);
      ST_DUM:  after_st = dat_q ? ST_DAT : ST_FIN;
      default: after_st = ST_FIN;
    endcase
    t_st = ph_over ? after_st : st;
    if (!ph_over)               t_left = beat_on ? left - LW'(1) : left;
    else if (after_st == ST_DUM) t_left = LW'(dum_q);
    else                         t_left = '0;
  end

  generate
    if (BUS_W >= 16) begin : g_swap
      for (genvar k = 0; k < BUS_W / 16; k++) begin : g_lane
        assign sw_d[16*k +: 8]   = cfg_byte_swap ? s_data[16*k+8 +: 8] : s_data[16*k +: 8];
        assign sw_d[16*k+8 +: 8] = cfg_byte_swap ? s_data[16*k +: 8]   : s_data[16*k+8 +: 8];
      end
      if (BUS_W % 16 != 0) begin : g_tail
        assign sw_d[BUS_W-1 : (BUS_W/16)*16] = s_data[BUS_W-1 : (BUS_W/16)*16];
      end
    end else begin : g_noswap
      assign sw_d = s_data;
    end
    for (genvar i = 0; i < BUS_W; i++) begin : g_rev
      assign rv_d[i] = sw_d[BUS_W-1-i];
    end
  endgenerate

  assign fmt_d = cfg_bit_rev ? rv_d : sw_d;

  always_comb begin
    case (t_st)
      ST_CMD:  word = cmd_sh[CMD_W-1 -: BUS_W];
      ST_DAT:  word = fmt_d;
      default: word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      beat_on <= 1'b0;
      cnt     <= '0;
      left    <= '0;
      last_q  <= 1'b0;
      dat_q   <= 1'b0;
      dum_q   <= '0;
      cmd_sh  <= '0;
      bus_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start && start_ok) begin
          st      <= first_st;
          left    <= first_left;
          dum_q   <= dummy_beats;
          dat_q   <= has_data;
          cmd_sh  <= cmd_aligned;
          beat_on <= 1'b0;
        end
        ST_FIN: st <= ST_IDLE;
        default: begin
          if (at_bound) begin
            st   <= t_st;
            left <= t_left;
            if (go) begin
              beat_on <= 1'b1;
              cnt     <= '0;
              bus_q   <= word;
              if (t_st == ST_CMD) cmd_sh <= cmd_sh << BUS_W;
              if (t_st == ST_DAT) last_q <= s_last;
            end else begin
              beat_on <= 1'b0;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign s_ready   = at_bound && (t_st == ST_DAT);
  assign lcd_data  = bus_q;
  assign lcd_cs_n  = !in_phase;
  assign lcd_wr    = !in_phase ? cfg_wr_idle_hi :
                     (beat_on && (cnt >= {1'b0, cfg_prescale})) ? !cfg_sample_fall : cfg_sample_fall;
  assign lcd_dc    = (st == ST_CMD) ? cfg_dc_cmd :
                     (st == ST_DUM) ? cfg_dc_dummy :
                     (st == ST_DAT) ? cfg_dc_data : cfg_dc_idle;
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_FIN);
  assign start_rej = (st == ST_IDLE) && start && !start_ok;

endmodule

module disp8080_wr_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_idle_hi,
  input logic             cfg_sample_fall,
  input logic             cfg_dc_idle,
  input logic             s_ready,
  input logic [BUS_W-1:0] lcd_data,
  input logic             lcd_wr,
  input logic             lcd_dc,
  input logic             lcd_cs_n,
  input logic             busy,
  input logic             done,
  input logic             start_rej
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lcd_cs_n && (lcd_dc == cfg_dc_idle) && (lcd_wr == cfg_wr_idle_hi)));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && !$past(lcd_cs_n) && (lcd_wr != $past(lcd_wr)) && (lcd_wr != cfg_sample_fall))
    |-> $stable(lcd_data));

  // R6
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && !lcd_cs_n));

  // R10
  reject_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej |=> !busy);

  // R3
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lcd_cs_n && (lcd_dc == cfg_dc_idle)));

  // R12
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

bind disp8080_wr disp8080_wr_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_idle_hi(cfg_wr_idle_hi),
  .cfg_sample_fall(cfg_sample_fall), .cfg_dc_idle(cfg_dc_idle),
  .s_ready(s_ready), .lcd_data(lcd_data), .lcd_wr(lcd_wr), .lcd_dc(lcd_dc),
  .lcd_cs_n(lcd_cs_n), .busy(busy), .done(done), .start_rej(start_rej)
);

// File: tb/disp8080_wr_tb.sv
module disp8080_wr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W = 16, CMD_W = 32, PRE_MAX = 8, DUM_W = 4;
  localparam int PRE_W = $clog2(PRE_MAX + 1);
  localparam int CWW   = $clog2(CMD_W + 1);

  typedef struct packed {
    logic [31:0] cmd;
    logic [5:0]  cwid;
    logic [3:0]  dum;
    logic [3:0]  nd;
    logic [3:0]  pre;
    logic        fall;
    logic        idle_hi;
    logic        rev;
    logic        swap;
    logic [3:0]  dcl;   // {idle, cmd, dummy, data}
    logic        stall;
    logic [15:0] seed;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000002C, 6'd8,  4'd0, 4'd3, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101, 1'b0, 16'h1000},
    '{32'h12345678, 6'd32, 4'd2, 4'd2, 4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1010, 1'b0, 16'hA5C3},
    '{32'h00ABCDEF, 6'd24, 4'd0, 4'd4, 4'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0110, 1'b1, 16'h0F01},
    '{32'hFFFFBEEF, 6'd16, 4'd1, 4'd2, 4'd1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1001, 1'b0, 16'h1234},
    '{32'h00000036, 6'd8,  4'd0, 4'd0, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100, 1'b0, 16'h0000},
    '{32'h00001234, 6'd16, 4'd3, 4'd1, 4'd8, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0011, 1'b1, 16'h8001},
    '{32'h00000000, 6'd0,  4'd1, 4'd0, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1101, 1'b0, 16'h0000},
    '{32'h00000000, 6'd0,  4'd0, 4'd2, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1000, 1'b0, 16'h00FF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PRE_W-1:0] cfg_prescale = PRE_W'(1);
  logic cfg_wr_idle_hi = 1'b1, cfg_sample_fall = 1'b0;
  logic cfg_dc_idle = 1'b1, cfg_dc_cmd = 1'b0, cfg_dc_dummy = 1'b0, cfg_dc_data = 1'b1;
  logic cfg_bit_rev = 1'b0, cfg_byte_swap = 1'b0;
  logic start = 1'b0;
  logic [CMD_W-1:0] cmd_value = '0;
  logic [CWW-1:0] cmd_width = '0;
  logic [DUM_W-1:0] dummy_beats = '0;
  logic has_data = 1'b0;
  logic [BUS_W-1:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic s_ready, lcd_wr, lcd_dc, lcd_cs_n, busy, done, start_rej;
  logic [BUS_W-1:0] lcd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp8080_wr #(.BUS_W(BUS_W), .CMD_W(CMD_W), .PRE_MAX(PRE_MAX), .DUM_W(DUM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale),
    .cfg_wr_idle_hi(cfg_wr_idle_hi), .cfg_sample_fall(cfg_sample_fall),
    .cfg_dc_idle(cfg_dc_idle), .cfg_dc_cmd(cfg_dc_cmd), .cfg_dc_dummy(cfg_dc_dummy),
    .cfg_dc_data(cfg_dc_data), .cfg_bit_rev(cfg_bit_rev), .cfg_byte_swap(cfg_byte_swap),
    .start(start), .cmd_value(cmd_value), .cmd_width(cmd_width),
    .dummy_beats(dummy_beats), .has_data(has_data), .s_data(s_data),
    .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready), .lcd_data(lcd_data),
    .lcd_wr(lcd_wr), .lcd_dc(lcd_dc), .lcd_cs_n(lcd_cs_n), .busy(busy),
    .done(done), .start_rej(start_rej)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_got = 0, done_cnt = 0, n_unstable = 0, rej_seen = 0;
  logic [BUS_W-1:0] got_d [64];
  logic             got_dc [64];
  int               got_t [64];
  logic [BUS_W-1:0] exp_d [64];
  logic             exp_dc [64];
  int               n_exp = 0;
  logic d_cs, d_dc, d_wr;
  logic prev_wr = 1'b1;
  logic [BUS_W-1:0] prev_data = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // bus monitor: logs every sampling edge seen while chip select is active
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!lcd_cs_n && lcd_wr != prev_wr && lcd_wr == !cfg_sample_fall) begin
        if (n_got < 64) begin
          got_d[n_got] = lcd_data;
          got_dc[n_got] = lcd_dc;
          got_t[n_got] = cyc;
        end
        n_got++;
        if (lcd_data != prev_data) n_unstable++;
      end
      if (done) begin
        done_cnt++;
        d_cs = lcd_cs_n; d_dc = lcd_dc; d_wr = lcd_wr;
      end
      if (start_rej) rej_seen++;
    end
    prev_wr = lcd_wr;
    prev_data = lcd_data;
  end

  function automatic logic [15:0] wgen(input logic [15:0] seed, input int i);
    return seed + 16'(i) * 16'h0111;
  endfunction

  function automatic logic [15:0] fmt(input logic [15:0] w, input logic sw, input logic rv);
    logic [15:0] a, b;
    a = sw ? {w[7:0], w[15:8]} : w;
    for (int i = 0; i < 16; i++) b[i] = a[15-i];
    return rv ? b : a;
  endfunction

  task automatic apply_cfg(input vec_t v);
    cfg_prescale = PRE_W'(v.pre);
    cfg_sample_fall = v.fall; cfg_wr_idle_hi = v.idle_hi;
    cfg_bit_rev = v.rev; cfg_byte_swap = v.swap;
    {cfg_dc_idle, cfg_dc_cmd, cfg_dc_dummy, cfg_dc_data} = v.dcl;
    cmd_value = v.cmd; cmd_width = CWW'(v.cwid);
    dummy_beats = DUM_W'(v.dum); has_data = (v.nd != 0);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int nc, d0, i;
    logic [31:0] al;
    bit ok;
    apply_cfg(v);
    nc = (int'(v.cwid) + BUS_W - 1) / BUS_W;
    al = (v.cwid == 32) ? v.cmd : (v.cmd & ((32'h1 << v.cwid) - 32'h1));
    al = al << (32 - nc * BUS_W);
    n_exp = 0;
    for (int k = 0; k < nc; k++) begin
      exp_d[n_exp] = al[31 - 16*k -: 16]; exp_dc[n_exp] = v.dcl[2]; n_exp++;
    end
    for (int k = 0; k < int'(v.dum); k++) begin
      exp_d[n_exp] = '0; exp_dc[n_exp] = v.dcl[1]; n_exp++;
    end
    for (int k = 0; k < int'(v.nd); k++) begin
      exp_d[n_exp] = fmt(wgen(v.seed, k), v.swap, v.rev); exp_dc[n_exp] = v.dcl[0]; n_exp++;
    end
    @(negedge clk);
    n_got = 0; n_unstable = 0; d0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (v.nd != 0) begin
      i = 0;
      s_data = wgen(v.seed, 0); s_last = (v.nd == 1); s_valid = 1'b1;
      while (i < int'(v.nd)) begin
        #1 ok = s_ready;
        @(negedge clk);
        if (ok) begin
          i++;
          if (i < int'(v.nd)) begin
            if (v.stall) begin
              s_valid = 1'b0;
              repeat (3) @(negedge clk);
            end
            s_data = wgen(v.seed, i); s_last = (i == int'(v.nd) - 1); s_valid = 1'b1;
          end else begin
            s_valid = 1'b0; s_last = 1'b0;
          end
        end
      end
    end
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    // R1 beat count across phases (stalls must add no edges: R6)
    check(n_got == n_exp, $sformatf("R1/R6 vec%0d beat count", idx), 32'(n_got), 32'(n_exp));
    for (int k = 0; k < n_exp && k < n_got; k++) begin
      // R2 command order, R8 dummy zero, R7 data format
      check(got_d[k] == exp_d[k], $sformatf("R2/R7/R8 vec%0d beat%0d data", idx, k), 32'(got_d[k]), 32'(exp_d[k]));
      check(got_dc[k] == exp_dc[k], $sformatf("R3 vec%0d beat%0d dc", idx, k), 32'(got_dc[k]), 32'(exp_dc[k]));
    end
    check(n_unstable == 0, $sformatf("R5 vec%0d data moved at sample edge", idx), 32'(n_unstable), 0);
    if (nc + int'(v.dum) >= 2 && n_got >= 2)
      check(got_t[1] - got_t[0] == 2 * int'(v.pre), $sformatf("R4 vec%0d beat spacing", idx),
            32'(got_t[1] - got_t[0]), 32'(2 * int'(v.pre)));
    check(done_cnt - d0 == 1, $sformatf("R9 vec%0d done pulses", idx), 32'(done_cnt - d0), 1);
    check({d_cs, d_dc, d_wr} == {1'b1, v.dcl[3], v.idle_hi}, $sformatf("R9 vec%0d bus at rest on done", idx),
          32'({d_cs, d_dc, d_wr}), 32'({1'b1, v.dcl[3], v.idle_hi}));
    check(lcd_wr == v.idle_hi && lcd_dc == v.dcl[3], $sformatf("R4 vec%0d resting levels", idx),
          32'({lcd_wr, lcd_dc}), 32'({v.idle_hi, v.dcl[3]}));
  endtask

  task automatic try_reject(input logic [PRE_W-1:0] pre, input logic [CWW-1:0] cw, input string what);
    int d0, r0;
    cfg_prescale = pre; cmd_width = cw; cmd_value = 32'h55;
    dummy_beats = 4'd1; has_data = 1'b0;
    @(negedge clk);
    d0 = done_cnt; r0 = rej_seen; n_got = 0;
    start = 1'b1;
    #1 check(start_rej == 1'b1, {"R10 start_rej ", what}, 32'(start_rej), 1);
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    check(busy == 1'b0 && lcd_cs_n == 1'b1, {"R10 bus stays at rest ", what}, 32'({busy, lcd_cs_n}), 32'h1);
    check(done_cnt == d0 && n_got == 0, {"R10 no done/edges ", what}, 32'(done_cnt - d0 + n_got), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(busy == 0 && done == 0 && s_ready == 0, "R11 status after reset", 32'({busy, done, s_ready}), 0);
    check(lcd_cs_n == 1 && lcd_wr == 1 && lcd_dc == 1, "R11 lines after reset",
          32'({lcd_cs_n, lcd_wr, lcd_dc}), 32'h7);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

    // R10 refused starts
    cfg_wr_idle_hi = 1'b1; cfg_sample_fall = 1'b0;
    try_reject(PRE_W'(0), CWW'(8), "prescale 0");
    try_reject(PRE_W'(9), CWW'(8), "prescale 9");
    try_reject(PRE_W'(2), CWW'(33), "width 33");

    // R12 start while busy is ignored
    cfg_prescale = PRE_W'(3); cmd_width = '0; dummy_beats = 4'd2; has_data = 1'b0;
    @(negedge clk);
    d0 = done_cnt; n_got = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    check(done_cnt - d0 == 1, "R12 one done for one accepted start", 32'(done_cnt - d0), 1);
    check(n_got == 2, "R12 no extra beats", 32'(n_got), 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule